// File: doc/BRIEF.md
# Word-Parallel Three-Valued Fault Lane Evaluator

This block evaluates one logic gate across a whole word of circuit copies in a single cycle, for use inside a parallel fault-simulation engine. Each bit lane is a separate copy of the circuit. Lane 0 is the fault-free machine, and every other lane carries one injected stuck-at fault. A lane value is three-valued (0, 1 or unknown X) and is stored as one bit in each of two bit-planes, `hi` and `lo`.

A sequencer outside this block walks the netlist. For each gate it presents the two operand words and an op code, together with per-lane stuck-at masks for the node being written. One cycle later the block returns the result word. It also returns a detect vector that marks every faulty lane whose known value differs from the known value of the good lane.

Top module: `fault_lane_eval`

## Requirements
- R1: Lane i of a value is the bit pair (hi[i], lo[i]), with 0 = (0,0), 1 = (1,1) and X = (1,0). After reset, `res_valid` is 0, both result planes are all-zero and `detect` is all-zero.
- R2: Op code 0 gives the lane-wise AND. A 0 on either input gives 0, 1 with 1 gives 1, and any other mix gives X.
- R3: Op code 1 gives the lane-wise OR. A 1 on either input gives 1, 0 with 0 gives 0, and any other mix gives X.
- R4: Op code 2 gives NOT of operand A, with X staying X. Operand B has no effect on the result.
- R5: Op code 3 gives NAND and op code 4 gives NOR, each being the inverse of R2 or R3 under the NOT rule of R4.
- R6: Op code 5 gives XOR. It is X whenever either input is X, and otherwise it is the exclusive-or of the two known values.
- R7: Op codes 6 and 7 give X on every lane.
- R8: The stuck-at masks apply after the gate is evaluated. A lane set in `stuck1` reads 1. A lane set only in `stuck0` reads 0. When both masks are set on a lane, 1 wins. Lane 0 may be forced like any other lane.
- R9: `detect[i]` is 1 only when lane i of the result is known, lane 0 of the result is known, and the two lanes differ. `detect[0]` is therefore always 0.
- R10: The result, the detect vector and a one-cycle `res_valid` pulse appear on the clock edge that samples `op_valid`. While `op_valid` is low, the result and the detect vector hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operands and op code are valid this cycle |
| op_code | input | 3 | Gate function select (R2 to R7) |
| a_hi | input | LANES | Operand A, hi plane |
| a_lo | input | LANES | Operand A, lo plane |
| b_hi | input | LANES | Operand B, hi plane |
| b_lo | input | LANES | Operand B, lo plane |
| stuck0 | input | LANES | Per-lane stuck-at-0 mask |
| stuck1 | input | LANES | Per-lane stuck-at-1 mask |
| res_valid | output | 1 | Result valid pulse |
| res_hi | output | LANES | Result, hi plane |
| res_lo | output | LANES | Result, lo plane |
| detect | output | LANES | Faulty lanes observed to differ from lane 0 |

## Verification
Stuck-at forcing and fault detection resolve in the same cycle. The detect vector is compared against the forced result, so a mask on lane 0 moves the reference that every other lane is judged by. The bench provokes this with vectors that force lane 0 to the opposite of its computed value, vectors that set both masks on one lane, and vectors that force faulty lanes onto or off the good value. Its lane-by-lane model forces first and then derives the expected detect bits from the forced good lane.

// File: rtl/fault_lane_eval.sv
module fault_lane_eval #(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [LANES-1:0] a_hi,
  input  logic [LANES-1:0] a_lo,
  input  logic [LANES-1:0] b_hi,
  input  logic [LANES-1:0] b_lo,
  input  logic [LANES-1:0] stuck0,
  input  logic [LANES-1:0] stuck1,
  output logic             res_valid,
  output logic [LANES-1:0] res_hi,
  output logic [LANES-1:0] res_lo,
  output logic [LANES-1:0] detect
);

  localparam logic [LANES-1:0] ALL1 = {LANES{1'b1}};

  logic [LANES-1:0] and_hi, and_lo, or_hi, or_lo, xor_hi, xor_lo;
  logic [LANES-1:0] g_hi, g_lo, f_hi, f_lo, known, good_val;
  logic             good_known;

  // plane-wise AND / OR; NOT swaps planes with inversion
  assign and_hi = a_hi & b_hi;
  assign and_lo = a_lo & b_lo;
  assign or_hi  = a_hi | b_hi;
  assign or_lo  = a_lo | b_lo;
  // XOR as (A & ~B) | (~A & B), composed from the three primitives
  assign xor_hi = (a_hi & ~b_lo) | (~a_lo & b_hi);
  assign xor_lo = (a_lo & ~b_hi) | (~a_hi & b_lo);

  always_comb begin
    case (op_code)
      3'd0:    begin g_hi = and_hi; g_lo = and_lo; end
      3'd1:    begin g_hi = or_hi;  g_lo = or_lo;  end
      3'd2:    begin g_hi = ~a_lo;  g_lo = ~a_hi;  end
      3'd3:    begin g_hi = ~and_lo; g_lo = ~and_hi; end
      3'd4:    begin g_hi = ~or_lo;  g_lo = ~or_hi;  end
      3'd5:    begin g_hi = xor_hi; g_lo = xor_lo; end
      default: begin g_hi = ALL1;   g_lo = '0;     end
    endcase
  end

  // stuck-at override, stuck1 dominant
  assign f_hi = (g_hi & ~stuck0) | stuck1;
  assign f_lo = (g_lo & ~stuck0) | stuck1;

  assign known      = ~(f_hi ^ f_lo);
  assign good_known = known[0];
  assign good_val   = {LANES{f_lo[0]}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hi    <= '0;
      res_lo    <= '0;
      detect    <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_hi <= f_hi;
        res_lo <= f_lo;
        detect <= good_known ? (known & (f_lo ^ good_val)) : '0;
      end
    end
  end

  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(res_hi) && $stable(res_lo) && $stable(detect)));
  a_r9_lane0_clear: assert property (@(posedge clk) disable iff (!rst_n)
    detect[0] == 1'b0);
  a_r9_known_only: assert property (@(posedge clk) disable iff (!rst_n)
    (detect & (res_hi ^ res_lo)) == '0);
  a_r8_stuck1_wins: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> ((res_hi & res_lo & $past(stuck1)) == $past(stuck1)));
  a_r8_stuck0: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (((res_hi | res_lo) & $past(stuck0) & ~$past(stuck1)) == '0));
  a_r1_legal_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (((a_lo & ~a_hi) | (b_lo & ~b_hi)) == '0)) |=> ((res_lo & ~res_hi) == '0));

endmodule

// File: tb/fault_lane_eval_tb_top.sv
module fault_lane_eval_tb_top;
  localparam int LANES = 32;
  localparam int W = 3 * LANES;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             op_valid = 0;
  logic [2:0]       op_code = 0;
  logic [LANES-1:0] a_hi = 0, a_lo = 0, b_hi = 0, b_lo = 0, stuck0 = 0, stuck1 = 0;
  logic             res_valid;
  logic [LANES-1:0] res_hi, res_lo, detect;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [31:0]  seed = 32'h1234_5678;
  bit           done = 0;

  always #10 clk = ~clk;

  fault_lane_eval #(.LANES(LANES)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
    .stuck0(stuck0), .stuck1(stuck1), .res_valid(res_valid),
    .res_hi(res_hi), .res_lo(res_lo), .detect(detect));

  // lane values: 0, 1, 2 = X
  function automatic int dec(logic h, logic l);
    if (h && l) return 1;
    if (!h && !l) return 0;
    return 2;
  endfunction
  function automatic int n3(int a);
    return (a == 2) ? 2 : 1 - a;
  endfunction
  function automatic int and3(int a, int b);
    if (a == 0 || b == 0) return 0;
    if (a == 1 && b == 1) return 1;
    return 2;
  endfunction
  function automatic int or3(int a, int b);
    if (a == 1 || b == 1) return 1;
    if (a == 0 && b == 0) return 0;
    return 2;
  endfunction
  function automatic int gate3(int op, int a, int b);
    case (op)
      0: return and3(a, b);
      1: return or3(a, b);
      2: return n3(a);
      3: return n3(and3(a, b));
      4: return n3(or3(a, b));
      5: return (a == 2 || b == 2) ? 2 : (a ^ b);
      default: return 2;
    endcase
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0: return "R2 AND";
      1: return "R3 OR";
      2: return "R4 NOT";
      3: return "R5 NAND";
      4: return "R5 NOR";
      5: return "R6 XOR";
      default: return "R7 undefined op";
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one operation and push its expectation
  task automatic drive(int op, logic [LANES-1:0] ah, al, bh, bl, s0, s1, string extra);
    logic [LANES-1:0] eh, el, ed;
    int v[LANES];
    for (int i = 0; i < LANES; i++) begin
      v[i] = gate3(op, dec(ah[i], al[i]), dec(bh[i], bl[i]));
      if (s1[i]) v[i] = 1;
      else if (s0[i]) v[i] = 0;
      eh[i] = (v[i] != 0);
      el[i] = (v[i] == 1);
    end
    for (int i = 0; i < LANES; i++)
      ed[i] = (v[i] != 2) && (v[0] != 2) && (v[i] != v[0]);
    exp_q.push_back({eh, el, ed});
    tag_q.push_back({op_tag(op), extra});
    @(negedge clk);
    op_valid = 1; op_code = op[2:0];
    a_hi = ah; a_lo = al; b_hi = bh; b_lo = bl; stuck0 = s0; stuck1 = s1;
    @(negedge clk);
    op_valid = 0;
    a_hi = rnd(); b_lo = rnd(); op_code = 3'd6;
  endtask

  // random legal operand (no 01 codes)
  task automatic rand_val(output logic [LANES-1:0] h, output logic [LANES-1:0] l);
    logic [LANES-1:0] k, x;
    k = rnd(); x = rnd() & rnd();
    h = k | x;
    l = k & ~x;
  endtask

  // monitor: pop and compare on every result
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      logic [W-1:0] e;
      string t;
      if (exp_q.size() == 0) begin
        check("R10 unexpected res_valid", 1, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " R1 result planes"}, {res_hi, res_lo}, e[W-1:LANES]);
        check({t, " R9 detect"}, detect, e[LANES-1:0]);
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [LANES-1:0] ah, al, bh, bl, hold_h, hold_l, hold_d;
    repeat (3) @(negedge clk);
    check("R1 reset state", {31'd0, res_valid, res_hi, res_lo, detect}, '0);
    rst_n = 1;
    @(negedge clk);

    // directed: exhaustive 3x3 combos across lanes 1..9, lane 0 known
    ah = 0; al = 0; bh = 0; bl = 0;
    for (int i = 0; i < 9; i++) begin
      int av = i / 3, bv = i % 3;
      ah[i+1] = (av != 0); al[i+1] = (av == 1);
      bh[i+1] = (bv != 0); bl[i+1] = (bv == 1);
    end
    for (int op = 0; op < 8; op++) drive(op, ah, al, bh, bl, 0, 0, " truth table");

    // R4: B has no effect on NOT
    drive(2, ah, al, 0, 0, 0, 0, " B zero");
    drive(2, ah, al, '1, '1, 0, 0, " B ones");

    // R6: all X operand
    drive(5, '1, '0, ah, al, 0, 0, " X input");

    // R8 with R9: force lane 0 to flip, both masks on one lane
    drive(0, '1, '1, '1, '1, 32'h0000_0001, 32'h0000_0002, " R8 lane0 forced 0");
    drive(1, '0, '0, '0, '0, 32'h0000_00F0, 32'h0000_00A1, " R8 both masks, lane0 forced 1");
    drive(0, '1, '0, '1, '0, 32'h0000_0F00, 32'h0000_F000, " R8 X good lane");

    // R10: hold across idle cycles
    repeat (2) @(negedge clk);
    hold_h = res_hi; hold_l = res_lo; hold_d = detect;
    repeat (4) @(negedge clk);
    check("R10 hold while idle", {res_hi, res_lo, detect}, {hold_h, hold_l, hold_d});
    check("R10 no pulse while idle", {31'd0, res_valid}, 32'd0);

    // random sweep over all ops with masks
    for (int n = 0; n < 48; n++) begin
      logic [LANES-1:0] s0, s1;
      rand_val(ah, al); rand_val(bh, bl);
      s0 = rnd() & rnd() & rnd();
      s1 = rnd() & rnd() & rnd();
      drive(n % 8, ah, al, bh, bl, s0, s1, " R8 random");
    end

    repeat (3) @(negedge clk);
    check("R10 all results delivered", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule